// File: doc/BRIEF.md
# Selectable Bit-Depth Reducer

This block is an audio bit-crusher datapath. On each input strobe it takes one left and one right 24-bit two's-complement sample and forms a mono mix from half of each channel. It then cuts the resolution of that mix by clearing the low bits of its magnitude. The number of bits it keeps is one of eight depths, picked by a 3-bit field of a 24-bit control word. The sign is put back after masking, so quantisation always truncates toward zero and never turns a negative sample positive. The result goes out on both channels with a one-cycle valid strobe.

The control word is captured on the same strobe as the audio, so a depth change always takes effect on a whole sample. Reset is synchronous and active high.

Top module: `bit_depth_reducer`

## Requirements
- R1: The mono value is `(L >>> 1) + (R >>> 1)`, where `>>>` is a signed shift that rounds toward minus infinity. For example, L = R = -1 gives -2.
- R2: Control bits 22:20 form a select code. Codes 0, 1, 2, 3, 4, 5, 6 and 7 keep 24, 16, 14, 12, 10, 8, 6 and 4 bits, in that order. All other control bits have no effect on the output.
- R3: For a mono value of zero or more, the output is that value with its low (24 - kept) bits cleared.
- R4: For a negative mono value, the output is minus the masked magnitude. It is never positive, and it is zero only when the magnitude masks to zero.
- R5: Select code 0 passes the mono value through unchanged.
- R6: The mono value -2^23 (0x800000) has its magnitude saturated to 0x7FFFFF before masking. With code 0 the output is 0x800001, and with code 7 it is 0x900000.
- R7: The left and right outputs carry the same value.
- R8: The output valid is high exactly in the cycle after a strobed input. The outputs keep their value in cycles with no strobe.
- R9: A synchronous reset clears both outputs and the output valid. Strobes seen during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| in_ctrl | input | 24 | Control word; bits 22:20 select the depth |
| out_left | output | 24 | Crushed sample, left |
| out_right | output | 24 | Crushed sample, right |
| out_valid | output | 1 | Output strobe |

## Verification
Every result is due in the cycle after its strobe, because exactly one register lies between the inputs and the outputs. The bench model captures its expected value and expected valid at the same rising edge the design uses. It compares all three outputs at the following falling edge, on every clock, including idle and reset cycles. In idle cycles this confirms that the outputs hold their value, and in reset cycles that they are cleared.

// File: rtl/bit_depth_reducer.sv
module bit_depth_reducer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic [W-1:0] in_ctrl,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right,
  output logic         out_valid
);
  localparam int SEL_W = 3;
  localparam int SEL_HI = W - 2;
  localparam int SEL_LO = W - 1 - SEL_W;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  function automatic logic [W-1:0] keep_mask(input logic [SEL_W-1:0] code);
    int keep;
    logic [W-1:0] m;
    keep = (code == '0) ? W : W - 6 - 2 * int'(code);
    m = '1;
    return m << (W - keep);
  endfunction

  logic signed [W-1:0] half_l, half_r;
  logic signed [W:0]   sum_wide;
  logic [W-1:0]        sum, mag, trunc, result;
  logic [SEL_W-1:0]    code;
  logic                neg;

  assign half_l   = $signed(in_left) >>> 1;
  assign half_r   = $signed(in_right) >>> 1;
  assign sum_wide = {half_l[W-1], half_l} + {half_r[W-1], half_r};
  assign sum      = sum_wide[W-1:0];
  assign neg      = sum[W-1];
  assign code     = in_ctrl[SEL_HI:SEL_LO];
  assign mag      = !neg ? sum : (sum == MOST_NEG) ? MOST_POS : -sum;
  assign trunc    = mag & keep_mask(code);
  assign result   = neg ? -trunc : trunc;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= result;
        out_right <= result;
      end
    end
  end

  p_sum_fits_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> sum_wide[W] == sum_wide[W-1]);
  p_pos_no_flip_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && !neg |=> !out_left[W-1]);
  p_neg_stays_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && neg |=> out_left[W-1] || out_left == '0);
  p_full_depth_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && code == '0 && sum != MOST_NEG |=> out_left == $past(sum));
  p_min_sat_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && code == '0 && sum == MOST_NEG |=> out_left == MOST_NEG + 1'b1);
  p_valid_next_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right));
endmodule

// File: tb/bit_depth_reducer_tb_top.sv
module bit_depth_reducer_tb_top;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [23:0] in_left = 0, in_right = 0, in_ctrl = 0;
  logic [23:0] out_left, out_right;
  logic out_valid;
  int compared = 0, mismatched = 0;
  logic [23:0] exp_out = 0;
  logic exp_valid = 0;
  string cur_tag = "R9", exp_tag = "R9";
  bit done = 0;

  always #5 clk = ~clk;

  bit_depth_reducer dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .in_ctrl(in_ctrl), .out_left(out_left), .out_right(out_right),
    .out_valid(out_valid));

  function automatic int half_floor(int x);
    return (x < 0 && (x % 2) != 0) ? x / 2 - 1 : x / 2;
  endfunction

  function automatic logic [23:0] model(logic [23:0] l, logic [23:0] r, logic [23:0] c);
    int li = $signed(l);
    int ri = $signed(r);
    int s = half_floor(li) + half_floor(ri);
    int code = int'(c[22:20]);
    int keep = (code == 0) ? 24 : 18 - 2 * code;
    int mag = (s < 0) ? -s : s;
    int step = 1 << (24 - keep);
    int res;
    if (mag > 8388607) mag = 8388607;
    mag = (mag / step) * step;
    res = (s < 0) ? -mag : mag;
    return res[23:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_out <= 0; exp_valid <= 0; exp_tag <= "R9";
    end else begin
      exp_valid <= in_valid;
      exp_tag <= in_valid ? cur_tag : "R8";
      if (in_valid) exp_out <= model(in_left, in_right, in_ctrl);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (out_valid !== exp_valid || out_left !== exp_out) begin
        mismatched++;
        $display("FAIL %s: valid=%b out=%h expected valid=%b out=%h", exp_tag,
                 out_valid, out_left, exp_valid, exp_out);
      end
      if (out_right !== out_left) begin
        mismatched++;
        $display("FAIL R7: right=%h expected %h", out_right, out_left);
      end
    end
  end

  task automatic send(logic [23:0] l, logic [23:0] r, logic [23:0] c, string tag);
    @(negedge clk);
    in_left = l; in_right = r; in_ctrl = c; in_valid = 1; cur_tag = tag;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        in_valid = 1; in_left = 24'h123456; in_right = 24'h123456;
        idle(3);
        rst = 0; in_valid = 0;
        idle(2);
        send(24'h000003, 24'h000001, 24'h0, "R1");
        send(24'hFFFFFF, 24'hFFFFFF, 24'h0, "R1");
        send(24'h123457, 24'h123457, 24'h100000, "R3");
        idle(3);
        send(24'hEDCBA9, 24'hEDCBA9, 24'h100000, "R4");
        send(24'h000100, 24'hFFFE00, 24'h700000, "R4");
        send(24'h400000, 24'h3FFFFE, 24'h0, "R5");
        send(24'h800000, 24'h800000, 24'h0, "R6");
        send(24'h800000, 24'h800000, 24'h700000, "R6");
        for (int k = 0; k < 8; k++) begin
          send(24'h3A5C97, 24'h2B1E33, 24'(k) << 20, "R2");
          send(24'hC5A369, 24'hD4E1CD, (24'(k) << 20) | 24'h8FFFFF, "R2");
        end
        idle(2);
        rst = 1; idle(1); rst = 0;
        idle(1);
        for (int i = 0; i < 300; i++) begin
          @(negedge clk);
          in_left = 24'($urandom); in_right = 24'($urandom);
          in_ctrl = 24'($urandom); in_valid = 1'($urandom); cur_tag = "R3";
        end
        @(negedge clk); in_valid = 0;
        idle(3);
      end
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule